// File: doc/BRIEF.md
# Interleaved Sync Word Correlator

This block watches a serial bit stream, one bit per strobe, and looks for a 35-bit synchronisation word whose bits sit between data bits rather than in one contiguous run. Every accepted bit is shifted into a window register. The window is compared with an expected pattern only at the positions a mask selects. The number of disagreeing bits is then compared with a 3-bit error limit written by the host. When the count is at or below the limit, the block declares sync. It raises a sticky interrupt flag and a sync status bit. It also latches the data positions of the window, descrambled by a fixed whitening word, into an output register for the host to read.

After a detection the correlator locks onto the block period. It will not declare sync again until a full block length of bits has arrived. At that boundary it correlates once more. A match renews the lock; a miss drops it and restarts the search. The host can force a restart with an acquire pulse. It can also stop the receiver with an enable bit, which freezes the window.

Top module: `sync_word_correlator`

## Requirements
- R1: After reset, irqFlags, statusReg, irqOut and blockData are all zero.
- R2: Each cycle with bitValid high and ctrlReg[5] high shifts bitIn into bit 0 of a WIN-bit window, so the first bit of a frame ends in bit WIN-1. Sync is declared when the number of SYNC_MASK positions where the new window differs from SYNC_PAT is less than or equal to ctrlReg[2:0].
- R3: On a declaration, irqFlags[7], irqOut and statusReg[7] are 1 from the clock edge that accepted the completing bit. All other bits of irqFlags and statusReg read 0.
- R4: A cycle with irqRead high clears irqFlags[7] and irqOut and leaves statusReg[7] unchanged. A declaration in the same cycle takes priority and leaves the flag set.
- R5: While ctrlReg[5] is 0, input bits are ignored and the window keeps its contents, and statusReg[7] is cleared.
- R6: While locked, no sync is declared until BLOCK_LEN accepted bits after the declaring bit. At the BLOCK_LEN-th bit the window is correlated again, and a match declares sync again.
- R7: A failed correlation at the block boundary clears statusReg[7] and returns the block to searching on every bit.
- R8: A cycle with ctrlReg[7] (acquire) high clears irqFlags[7], statusReg[7] and the lock. The window is kept.
- R9: On each declaration blockData is loaded with (window XOR WHITEN) AND NOT SYNC_MASK. It holds that value until the next declaration.
- R10: The values at non-mask (data) positions have no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitIn | input | 1 | Received serial bit |
| bitValid | input | 1 | Strobe marking bitIn as a new bit |
| ctrlReg | input | 8 | Control: [2:0] error limit, [5] receiver enable, [7] acquire pulse |
| irqRead | input | 1 | Host read strobe of the interrupt flag register |
| irqFlags | output | 8 | Interrupt flags, [7] sticky sync flag |
| statusReg | output | 8 | Status, [7] sync held |
| irqOut | output | 1 | Interrupt request, follows irqFlags[7] |
| blockData | output | WIN | Descrambled data positions captured at sync |

## Verification
The hardest state to reach from the ports is the block boundary of a lock. At that point a correctly placed pattern must re-declare sync, while an identical pattern arriving a few bits earlier must not. The bench counts bits exactly from the declaring bit. It first plants a full valid frame inside the lock window and checks that no flag appears. It then completes a second frame on precisely the BLOCK_LEN-th bit, and repeats the run with a corrupted boundary frame to force loss of lock. Window retention across a disable is checked by splitting one frame around a burst of ignored bits.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  typedef enum logic {ST_SEARCH, ST_LOCK} corrState_t;

  typedef struct packed {
    logic shiftEn;
    logic capture;
  } corrStrobe_t;
endpackage

// File: rtl/sync_corr_dp.sv
module sync_corr_dp
  import sync_corr_pkg::*;
#(
  parameter int WIN = 42,
  parameter logic [WIN-1:0] SYNC_PAT = '0,
  parameter logic [WIN-1:0] SYNC_MASK = '1,
  parameter logic [WIN-1:0] WHITEN = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic [2:0] errLimit,
  input  corrStrobe_t strobe,
  output logic hit,
  output logic [WIN-1:0] blockData
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [WIN-1:0] window;
  logic [WIN-1:0] nextWin;
  logic [CNT_W-1:0] mismatchCnt;

  assign nextWin = {window[WIN-2:0], bitIn};

  always_comb begin
    mismatchCnt = CNT_W'($countones((nextWin ^ SYNC_PAT) & SYNC_MASK));
    hit = mismatchCnt <= CNT_W'(errLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window <= '0;
      blockData <= '0;
    end else begin
      if (strobe.shiftEn) window <= nextWin;
      if (strobe.capture) blockData <= (nextWin ^ WHITEN) & ~SYNC_MASK;
    end
  end

  // R9: capture only follows a correlation hit
  a_r9_capture_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> hit);
  // R9: captured data holds between declarations
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(blockData));
  // R5: window frozen without an accepted bit
  a_r5_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(window));
endmodule

// File: rtl/sync_corr_ctrl.sv
module sync_corr_ctrl
  import sync_corr_pkg::*;
#(
  parameter int BLOCK_LEN = 96
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic rxEnable,
  input  logic acqPulse,
  input  logic irqRead,
  input  logic hit,
  output corrStrobe_t strobe,
  output logic syncFlag,
  output logic syncStatus
);
  localparam int CNT_W = $clog2(BLOCK_LEN + 1);

  corrState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic atBoundary;
  logic declare;

  always_comb begin
    atBoundary = (state == ST_LOCK) && (bitCnt == CNT_W'(BLOCK_LEN));
    strobe.shiftEn = bitValid & rxEnable;
    declare = strobe.shiftEn & ~acqPulse & hit & ((state == ST_SEARCH) | atBoundary);
    strobe.capture = declare;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_SEARCH;
      bitCnt <= '0;
      syncStatus <= 1'b0;
      syncFlag <= 1'b0;
    end else begin
      if (!rxEnable || acqPulse) begin
        state <= ST_SEARCH;
        bitCnt <= '0;
        syncStatus <= 1'b0;
      end else if (strobe.shiftEn) begin
        if (declare) begin
          state <= ST_LOCK;
          bitCnt <= CNT_W'(1);
          syncStatus <= 1'b1;
        end else if (atBoundary) begin
          state <= ST_SEARCH;
          bitCnt <= '0;
          syncStatus <= 1'b0;
        end else if (state == ST_LOCK) begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
      if (acqPulse) syncFlag <= 1'b0;
      else if (declare) syncFlag <= 1'b1;
      else if (irqRead) syncFlag <= 1'b0;
    end
  end

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !syncStatus);
  a_r8_acq_clears: assert property (@(posedge clk) disable iff (!rstN)
    acqPulse |=> (!syncFlag && !syncStatus));
  a_r3_flag_with_status: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFlag) |-> syncStatus);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqRead && !bitValid) |=> !syncFlag);
  a_r6_no_early_redeclare: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && !atBoundary) |=> !$rose(syncFlag));
  a_r7_boundary_miss: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && atBoundary && !hit && !acqPulse) |=> !syncStatus);
endmodule

// File: rtl/sync_word_correlator.sv
module sync_word_correlator
  import sync_corr_pkg::*;
#(
  parameter int WIN = 42,
  parameter int BLOCK_LEN = 96,
  parameter logic [WIN-1:0] SYNC_PAT = 42'h1A5C3F09E6B,
  parameter logic [WIN-1:0] SYNC_MASK = 42'b011111_011111_011111_011111_011111_011111_011111,
  parameter logic [WIN-1:0] WHITEN = 42'h0F0F3C3CA5A
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic bitValid,
  input  logic [7:0] ctrlReg,
  input  logic irqRead,
  output logic [7:0] irqFlags,
  output logic [7:0] statusReg,
  output logic irqOut,
  output logic [WIN-1:0] blockData
);
  corrStrobe_t strobe;
  logic hit;
  logic syncFlag;
  logic syncStatus;
  logic ctrlUnused;

  assign ctrlUnused = ^{ctrlReg[6], ctrlReg[4:3]};

  sync_corr_ctrl #(.BLOCK_LEN(BLOCK_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxEnable(ctrlReg[5]),
    .acqPulse(ctrlReg[7]), .irqRead(irqRead), .hit(hit), .strobe(strobe),
    .syncFlag(syncFlag), .syncStatus(syncStatus)
  );

  sync_corr_dp #(.WIN(WIN), .SYNC_PAT(SYNC_PAT), .SYNC_MASK(SYNC_MASK), .WHITEN(WHITEN)) dp_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .errLimit(ctrlReg[2:0]), .strobe(strobe),
    .hit(hit), .blockData(blockData)
  );

  assign irqFlags = {syncFlag, 7'b0};
  assign statusReg = {syncStatus, 7'b0};
  assign irqOut = syncFlag;
endmodule

// File: tb/sync_word_correlator_tb_top.sv
`timescale 1ns/1ps
module sync_word_correlator_tb_top;
  localparam int W = 42;
  localparam int BL = 96;
  localparam logic [W-1:0] PAT = 42'h1A5C3F09E6B;
  localparam logic [W-1:0] MSK = 42'b011111_011111_011111_011111_011111_011111_011111;
  localparam logic [W-1:0] WH = 42'h0F0F3C3CA5A;
  localparam logic [W-1:0] DATA_FLIP = (42'd1 << 5) | (42'd1 << 11) | (42'd1 << 17) | (42'd1 << 23);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0;
  logic bitValid = 1'b0;
  logic [7:0] ctrlReg = 8'h20;
  logic irqRead = 1'b0;
  logic [7:0] irqFlags;
  logic [7:0] statusReg;
  logic irqOut;
  logic [W-1:0] blockData;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sync_word_correlator #(.WIN(W), .BLOCK_LEN(BL), .SYNC_PAT(PAT), .SYNC_MASK(MSK), .WHITEN(WH)) dut_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .ctrlReg(ctrlReg),
    .irqRead(irqRead), .irqFlags(irqFlags), .statusReg(statusReg), .irqOut(irqOut),
    .blockData(blockData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic rd);
    @(negedge clk);
    bitIn = b; bitValid = 1'b1; irqRead = rd;
    @(negedge clk);
    bitValid = 1'b0; irqRead = 1'b0;
  endtask

  task automatic sendFrame(input logic [W-1:0] f, input logic rdLast);
    for (int i = W - 1; i >= 0; i--) sendBit(f[i], rdLast && (i == 0));
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0, 1'b0);
  endtask

  task automatic pulseAcq();
    @(negedge clk); ctrlReg = ctrlReg | 8'h80;
    @(negedge clk); ctrlReg = ctrlReg & 8'h7F;
  endtask

  task automatic hostRead();
    @(negedge clk); irqRead = 1'b1;
    @(negedge clk); irqRead = 1'b0;
  endtask

  task automatic testReset();
    check("R1 irqFlags", 64'(irqFlags), 64'h0);
    check("R1 statusReg", 64'(statusReg), 64'h0);
    check("R1 irqOut", 64'(irqOut), 64'h0);
    check("R1 blockData", 64'(blockData), 64'h0);
  endtask

  task automatic testDetect();
    logic [W-1:0] f;
    f = PAT ^ DATA_FLIP;
    pulseAcq();
    sendFrame(f, 1'b0);
    check("R3 irqFlags", 64'(irqFlags), 64'h80);
    check("R3 statusReg", 64'(statusReg), 64'h80);
    check("R3 irqOut", 64'(irqOut), 64'h1);
    check("R9 blockData", 64'(blockData), 64'((f ^ WH) & ~MSK));
  endtask

  task automatic testRead();
    hostRead();
    check("R4 flag cleared", 64'(irqFlags), 64'h0);
    check("R4 irqOut cleared", 64'(irqOut), 64'h0);
    check("R4 status kept", 64'(statusReg), 64'h80);
  endtask

  task automatic testLock();
    sendZeros(12);
    sendFrame(PAT, 1'b0);
    check("R6 no redeclare inside block", 64'(irqFlags), 64'h0);
    sendFrame(PAT, 1'b0);
    check("R6 redeclare at boundary", 64'(irqFlags), 64'h80);
    check("R6 status at boundary", 64'(statusReg), 64'h80);
    hostRead();
  endtask

  task automatic testLoss();
    sendZeros(BL - W);
    sendFrame(~PAT, 1'b0);
    check("R7 status dropped", 64'(statusReg), 64'h0);
    check("R7 no flag", 64'(irqFlags), 64'h0);
    sendFrame(PAT, 1'b0);
    check("R7 search resumed", 64'(statusReg), 64'h80);
  endtask

  task automatic testAcq();
    pulseAcq();
    check("R8 flag cleared", 64'(irqFlags), 64'h0);
    check("R8 status cleared", 64'(statusReg), 64'h0);
  endtask

  task automatic testThreshold();
    ctrlReg = 8'h23;
    pulseAcq();
    sendFrame(PAT ^ 42'h7, 1'b0);
    check("R2 three errors at limit three", 64'(statusReg), 64'h80);
    pulseAcq();
    sendFrame(PAT ^ 42'hF, 1'b0);
    check("R2 four errors over limit", 64'(statusReg), 64'h0);
    check("R2 four errors no flag", 64'(irqFlags), 64'h0);
    ctrlReg = 8'h20;
  endtask

  task automatic testDataBits();
    pulseAcq();
    sendFrame(PAT ^ DATA_FLIP ^ 42'h800, 1'b1);
    check("R10 data bits ignored", 64'(statusReg), 64'h80);
    check("R4 set wins over read", 64'(irqFlags), 64'h80);
  endtask

  task automatic testDisable();
    pulseAcq();
    for (int i = W - 1; i >= 22; i--) sendBit(PAT[i], 1'b0);
    ctrlReg = 8'h00;
    for (int i = 0; i < 30; i++) sendBit(1'b1, 1'b0);
    check("R5 no sync while disabled", 64'(statusReg), 64'h0);
    ctrlReg = 8'h20;
    for (int i = 21; i >= 0; i--) sendBit(PAT[i], 1'b0);
    check("R5 window kept across disable", 64'(statusReg), 64'h80);
    @(negedge clk); ctrlReg = 8'h00;
    @(negedge clk);
    check("R5 disable clears status", 64'(statusReg), 64'h0);
    ctrlReg = 8'h20;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDetect();
    testRead();
    testLock();
    testLoss();
    testAcq();
    testThreshold();
    testDataBits();
    testDisable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule